// File: doc/BRIEF.md
# I2C Line Control and Recovery Register

An 8-bit control register that sits beside an I2C controller and gives software direct command of the two open-drain bus lines. Software can pull SDA or SCL low, or release either one, by hand. It can read back both what the block is driving and the real level on each wire. It can also order one extra SCL pulse, which is used to free a target that is holding SDA low. The register holds the controller's shift engine in reset through a strobe. It also switches the pins between an active state and a released state.

Software writes the whole byte through a one-cycle write strobe. The read port always shows the current state. The two line inputs pass through a two-flop synchronizer before they reach the monitor bits. Each output is an open-drain enable: when it is high the pad pulls the wire low, and when it is low the wire is released to its external pull-up. The length of the extra SCL pulse comes from a half-period input, `half_div`. The block reads this value at the start of each half of the pulse.

Top module: `i2c_line_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h1F while both lines are high, and `sda_oe`, `scl_oe` and `eng_rst` are 0.
- R2: A write with bit 4 = 0 and bit 6 = 0 loads bit 3 into the SCL release latch and bit 2 into the SDA release latch (0 = pull low, 1 = release). While the block is enabled, the matching `*_oe` output is the inverse of its latch.
- R3: A write with bit 4 = 1 leaves both release latches unchanged, while bits 7, 6 and 5 are still written.
- R4: Read bit 4 is always 1.
- R5: Read bit 1 is the SCL line level and read bit 0 is the SDA line level, each delayed by two clock edges through the synchronizer.
- R6: A write with bits 7 and 5 set (and bit 6 clear) starts an extra SCL cycle. SCL is pulled low for `half_div`+1 clocks and then released for `half_div`+1 clocks. Read bit 5 stays 1 for the whole cycle and then clears itself.
- R7: A write that sets bit 5 with bit 7 = 0 starts no SCL cycle, and read bit 5 reads 0 afterwards.
- R8: While read bit 6 (internal reset) is 1, `eng_rst` is 1, both `*_oe` are 0 and both release latches are held released. The latches remain released after bit 6 is cleared.
- R9: While read bit 7 (enable) is 0, both `*_oe` are 0 and read bits 3 and 2 report 1. Clearing the enable bit cancels an extra SCL cycle that is in progress. Enabling the block again drives the values still held in the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: {enable, int reset, extra clock, 1, SCL released, SDA released, SCL level, SDA level} |
| half_div | input | DIV_W | Half-period of the extra SCL cycle, minus one |
| sda_in | input | 1 | SDA wire level |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | 1 = pull SDA low |
| scl_oe | output | 1 | 1 = pull SCL low |
| eng_rst | output | 1 | Reset strobe to the shift engine |

## Verification
The bound checker checks several rules on every cycle. The protect bit always reads as 1. No line is driven while the block is disabled or held in internal reset. An unprotected write lands in the release latches on the next cycle, and a protected write leaves them untouched. A recovery command issued with the enable bit clear never shows as pending. The bench scenarios cover the rest. They count the exact low and high halves of the extra SCL cycle for two divider values. They watch the two-edge delay of the monitor bits. They confirm that the latches stay released after the internal reset is removed, and that an extra SCL cycle stops when the block is disabled partway through.

// File: rtl/i2c_line_ctl.sv
module i2c_line_ctl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             eng_rst
);
  localparam int B_EN   = 7;
  localparam int B_IRST = 6;
  localparam int B_XCLK = 5;
  localparam int B_KEY  = 4;
  localparam int B_SCL  = 3;
  localparam int B_SDA  = 2;
  localparam logic [DIV_W-1:0] CNT_ZERO = '0;

  logic             en_q, irst_q, xclk_q, xhigh_q;
  logic [DIV_W-1:0] xcnt_q;
  logic             scl_rel_q, sda_rel_q;
  logic [1:0]       scl_sync_q, sda_sync_q;

  logic en_d, irst_d, ovr_wr, xstart, cnt_end;
  logic unused_wbits;

  assign en_d    = reg_wr ? reg_wdata[B_EN]   : en_q;
  assign irst_d  = reg_wr ? reg_wdata[B_IRST] : irst_q;
  assign ovr_wr  = reg_wr & ~reg_wdata[B_KEY];
  assign xstart  = reg_wr & reg_wdata[B_XCLK] & ~xclk_q;
  assign cnt_end = (xcnt_q == CNT_ZERO);
  assign unused_wbits = ^reg_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      irst_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      irst_q <= irst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_rel_q <= 1'b1;
      sda_rel_q <= 1'b1;
    end else if (irst_d) begin
      scl_rel_q <= 1'b1;
      sda_rel_q <= 1'b1;
    end else if (ovr_wr) begin
      scl_rel_q <= reg_wdata[B_SCL];
      sda_rel_q <= reg_wdata[B_SDA];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xclk_q  <= 1'b0;
      xhigh_q <= 1'b0;
      xcnt_q  <= '0;
    end else if (!en_d || irst_d) begin
      xclk_q  <= 1'b0;
      xhigh_q <= 1'b0;
    end else if (xstart) begin
      xclk_q  <= 1'b1;
      xhigh_q <= 1'b0;
      xcnt_q  <= half_div;
    end else if (xclk_q) begin
      if (!cnt_end) begin
        xcnt_q <= xcnt_q - 1'b1;
      end else if (xhigh_q) begin
        xclk_q  <= 1'b0;
        xhigh_q <= 1'b0;
      end else begin
        xhigh_q <= 1'b1;
        xcnt_q  <= half_div;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_in};
      sda_sync_q <= {sda_sync_q[0], sda_in};
    end
  end

  assign scl_oe  = en_q & ~irst_q & (~scl_rel_q | (xclk_q & ~xhigh_q));
  assign sda_oe  = en_q & ~irst_q & ~sda_rel_q;
  assign eng_rst = irst_q;

  assign reg_rdata = {en_q, irst_q, xclk_q, 1'b1, ~scl_oe, ~sda_oe,
                      scl_sync_q[1], sda_sync_q[1]};
endmodule

// File: rtl/i2c_line_ctl_chk.sv
module i2c_line_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       sda_rel,
  input logic       scl_rel
);
  logic unused_rd;
  assign unused_rd = ^reg_rdata[3:0];

  // R4
  key_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4]);

  // R9
  disabled_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7] |-> (!sda_oe && !scl_oe));

  // R8
  irst_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |-> (!sda_oe && !scl_oe && sda_rel && scl_rel));

  // R2
  ovr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[4] && !reg_wdata[6]) |=>
      (sda_rel == $past(reg_wdata[2]) && scl_rel == $past(reg_wdata[3])));

  // R3
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[4] && !reg_wdata[6]) |=> ($stable(sda_rel) && $stable(scl_rel)));

  // R7
  xclk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[5] && !reg_wdata[7]) |=> !reg_rdata[5]);
endmodule

bind i2c_line_ctl i2c_line_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .sda_rel(sda_rel_q), .scl_rel(scl_rel_q)
);

// File: tb/i2c_line_ctl_tb_top.sv
module i2c_line_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [DIV_W-1:0] half_div = '0;
  logic sda_oe, scl_oe, eng_rst;
  logic ext_sda = 1'b1, ext_scl = 1'b1;
  logic sda_in, scl_in;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in = ext_sda & ~sda_oe;
  assign scl_in = ext_scl & ~scl_oe;

  i2c_line_ctl #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .half_div(half_div), .sda_in(sda_in),
    .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe), .eng_rst(eng_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 8'h1F);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 scl_oe", scl_oe, 0);
    check("R1 eng_rst", eng_rst, 0);
  endtask

  task automatic t_override();
    wr(8'b1000_0000);
    check("R2 both low rd", reg_rdata[3:2], 2'b00);
    check("R2 both low oe", {scl_oe, sda_oe}, 2'b11);
    repeat (2) @(negedge clk);
    check("R5 lines low", reg_rdata[1:0], 2'b00);
    wr(8'b1000_0100);
    check("R2 sda rel rd", reg_rdata[3:2], 2'b01);
    check("R2 sda rel oe", {scl_oe, sda_oe}, 2'b10);
  endtask

  task automatic t_protect();
    wr(8'b1001_1000);
    check("R3 latches held rd", reg_rdata[3:2], 2'b01);
    check("R3 latches held oe", {scl_oe, sda_oe}, 2'b10);
    check("R4 key reads one", reg_rdata[4], 1);
    wr(8'b0001_1000);
    check("R3 enable still written", reg_rdata[7], 0);
    wr(8'b1001_0000);
    check("R3 latch kept after key", {scl_oe, sda_oe}, 2'b10);
    wr(8'b1000_1100);
    check("R2 both released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_monitor();
    repeat (3) @(negedge clk);
    ext_sda = 1'b0;
    @(negedge clk);
    check("R5 sda one edge", reg_rdata[0], 1);
    @(negedge clk);
    check("R5 sda two edges", reg_rdata[0], 0);
    ext_sda = 1'b1;
    ext_scl = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 scl level", reg_rdata[1:0], 2'b01);
    ext_scl = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 both high", reg_rdata[1:0], 2'b11);
  endtask

  task automatic t_xclk(input int div);
    int lo = 0, hi = 0;
    half_div = DIV_W'(div);
    wr(8'b1011_1100);
    for (int i = 0; i < 300 && scl_oe; i++) begin
      if (reg_rdata[5]) lo++;
      @(negedge clk);
    end
    for (int i = 0; i < 300 && reg_rdata[5] && !scl_oe; i++) begin
      hi++;
      @(negedge clk);
    end
    check("R6 low half", lo, div + 1);
    check("R6 high half", hi, div + 1);
    check("R6 self clear", reg_rdata[5], 0);
    check("R6 scl released", scl_oe, 0);
  endtask

  task automatic t_xclk_disabled();
    wr(8'b0011_1100);
    check("R7 no pending", reg_rdata[5], 0);
    check("R7 no pulse", scl_oe, 0);
    @(negedge clk);
    check("R7 still idle", scl_oe, 0);
  endtask

  task automatic t_irst();
    wr(8'b1000_0000);
    wr(8'b1100_0000);
    check("R8 strobe", eng_rst, 1);
    check("R8 oe released", {scl_oe, sda_oe}, 2'b00);
    check("R8 rd", reg_rdata[7:2], 6'b110111);
    wr(8'b1001_1100);
    check("R8 strobe off", eng_rst, 0);
    check("R8 latches stay released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_disable();
    wr(8'b1000_0000);
    wr(8'b0001_0000);
    check("R9 oe off", {scl_oe, sda_oe}, 2'b00);
    check("R9 rd released", reg_rdata[3:2], 2'b11);
    wr(8'b1001_0000);
    check("R9 latches reused", {scl_oe, sda_oe}, 2'b11);
    wr(8'b1000_1100);
    half_div = DIV_W'(5);
    wr(8'b1011_1100);
    @(negedge clk);
    check("R9 pulse running", scl_oe, 1);
    wr(8'b0001_1100);
    check("R9 cancel pending", reg_rdata[5], 0);
    check("R9 cancel scl", scl_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_override();
    t_protect();
    t_monitor();
    t_xclk(3);
    t_xclk(0);
    t_xclk_disabled();
    t_irst();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule